// File: doc/BRIEF.md
# Zero-Wait APB Word Memory Completer

This block is an APB completer with a word-wide memory behind it. Each transfer finishes in its access phase with ready high, so the block adds no wait states. A write merges its data into the addressed word one byte lane at a time, under the four strobe bits. A read returns the stored word. A mapped word that has not been written since reset reads as zero. Any address at or above the end of the mapped window gets a slave-error response.

A small phase machine follows the bus. It has three states:
- PH_IDLE: the completer was not selected on the last edge.
- PH_SETUP: a setup phase was seen on the last edge.
- PH_ACCESS: an access phase completed on the last edge.

It has these transitions:
- PH_IDLE to PH_SETUP on select without enable.
- PH_SETUP to PH_ACCESS on select with enable.
- PH_ACCESS to PH_SETUP on a back-to-back select without enable.
- Any state to PH_IDLE when select is low.

A transfer is accepted only when an enabled cycle follows a recorded setup phase. Every state change and every error indication is gated by that accepted access.

Storage is a parameter-deep array of words, indexed by `paddr[IDX_W+1:2]`. Each word has a valid bit. Reset clears only the valid bits, and a clear valid bit makes the word read as zero. Mapped addresses past the implemented depth alias onto the array.

Top module: `apb_mem_slave`

## Requirements
- R1: A transfer to a byte address below 32'h0010_0000 completes with `pslverr` low.
- R2: A write with `pstrb` = 4'hF stores all of `pwdata`. Strobe bit i covers `pwdata[8i+7:8i]`. A later read of that word returns the written value.
- R3: A write with a partial strobe updates only the strobed byte lanes. Every other lane keeps its previous contents.
- R4: A partial-strobe write to a word with no previous write sets every unstrobed lane to zero.
- R5: A read of a mapped word that has never been written returns 32'h0 with `pslverr` low.
- R6: A read at or above 32'h0010_0000 returns `prdata` = 32'h0 with `pslverr` high.
- R7: A write at or above 32'h0010_0000 raises `pslverr` and leaves every stored word unchanged, including the word its low bits alias to.
- R8: `pready` is high in every access phase, so transfers complete with no wait states.
- R9: Outside the access phase, `pslverr` is low, `prdata` is zero, and a setup phase alone changes no stored word.
- R10: Reset makes every previously written word read back as 32'h0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Completer select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 32 | Byte address |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte-lane write strobes |
| pready | output | 1 | Transfer complete (always high) |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Decode-miss error, access phase only |

## Verification
The bench writes to a word that was never written using a single strobed lane. A design that merged against stale array contents instead of zero would return garbage in the other lanes. It overlays partial strobes on an existing word, which catches a design that drops the strobes and overwrites the whole word. It writes to 32'h0010_0000, which aliases word 0. A design with a loose decode, or one that stored data on an error, would corrupt word 0 or fail to report the error. It also drives setup-only cycles and a mid-run reset, and probes the last mapped address 32'h000F_FFFC. These expose designs that commit on select alone, leak the error flag outside the access phase, fail to clear the valid bits, or place the window edge one word off.

// File: rtl/apbm_pkg.sv
package apbm_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;
endpackage

// File: rtl/apbm_phase_fsm.sv
module apbm_phase_fsm
    import apbm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic access_o,
    output logic ready_o
);
    phase_e state_q;
    phase_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: begin
                if (psel && !penable) state_d = PH_SETUP;
                else                  state_d = PH_IDLE;
            end
            PH_SETUP: begin
                if (psel && penable)  state_d = PH_ACCESS;
                else if (psel)        state_d = PH_SETUP;
                else                  state_d = PH_IDLE;
            end
            PH_ACCESS: begin
                if (psel && !penable) state_d = PH_SETUP;
                else                  state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    // outputs: an access is an enabled cycle that follows a recorded setup
    always_comb begin
        access_o = 1'b0;
        ready_o  = 1'b1;
        unique case (state_q)
            PH_IDLE:   access_o = 1'b0;
            PH_SETUP:  access_o = psel && penable;
            PH_ACCESS: access_o = 1'b0;
            default:   access_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/apbm_decode.sv
module apbm_decode #(
    parameter logic [31:0] MAP_LIMIT = 32'h0010_0000,
    parameter int unsigned IDX_W     = 8
) (
    input  logic [31:0]      paddr,
    output logic             mapped_o,
    output logic [IDX_W-1:0] idx_o
);
    assign mapped_o = (paddr < MAP_LIMIT);
    assign idx_o    = paddr[IDX_W+1:2];
endmodule

// File: rtl/apbm_store.sv
module apbm_store
    import apbm_pkg::*;
#(
    parameter int unsigned DEPTH = 256,
    parameter int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  strb,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  vld_q;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] merged;

    // a word never written since reset reads as zero
    assign cur_word = vld_q[idx] ? mem_q[idx] : '0;
    assign word_o   = cur_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = strb[g] ? wdata[g*8 +: 8] : cur_word[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     vld_q      <= '0;
        else if (wr_en) vld_q[idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[idx] <= merged;
    end
endmodule

// File: rtl/apb_mem_slave.sv
module apb_mem_slave
    import apbm_pkg::*;
#(
    parameter int unsigned DEPTH     = 256,
    parameter logic [31:0] MAP_LIMIT = 32'h0010_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [31:0] paddr,
    input  logic [31:0] pwdata,
    input  logic [3:0]  pstrb,
    output logic        pready,
    output logic [31:0] prdata,
    output logic        pslverr
);
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic             acc_fire;
    logic             mapped;
    logic [IDX_W-1:0] idx;
    logic [31:0]      word;
    logic             wr_en;

    apbm_phase_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .access_o (acc_fire),
        .ready_o  (pready)
    );

    apbm_decode #(.MAP_LIMIT(MAP_LIMIT), .IDX_W(IDX_W)) u_dec (
        .paddr    (paddr),
        .mapped_o (mapped),
        .idx_o    (idx)
    );

    assign wr_en = acc_fire && pwrite && mapped;

    apbm_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .idx    (idx),
        .wdata  (pwdata),
        .strb   (pstrb),
        .word_o (word)
    );

    assign prdata  = (acc_fire && !pwrite && mapped) ? word : '0;
    assign pslverr = acc_fire && !mapped;
endmodule

// File: rtl/apb_mem_slave_chk.sv
module apb_mem_slave_chk #(
    parameter int unsigned IDX_W     = 8,
    parameter logic [31:0] MAP_LIMIT = 32'h0010_0000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [31:0] paddr,
    input logic [31:0] pwdata,
    input logic [3:0]  pstrb,
    input logic        pready,
    input logic [31:0] prdata,
    input logic        pslverr
);
    a_r1_mapped_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && paddr < MAP_LIMIT) |-> !pslverr);

    a_r2_full_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr < MAP_LIMIT
         && $past(psel && penable && pwrite && pstrb == 4'hF && paddr < MAP_LIMIT, 3)
         && $past(!(psel && penable), 1) && $past(!(psel && penable), 2)
         && $past(paddr[IDX_W+1:2], 3) == paddr[IDX_W+1:2])
        |-> prdata == $past(pwdata, 3));

    a_r6_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && !pwrite && paddr >= MAP_LIMIT) |-> (pslverr && prdata == 32'h0));

    a_r7_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable && pwrite && paddr >= MAP_LIMIT) |-> pslverr);

    a_r8_ready_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && penable) |-> pready);

    a_r9_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable) |-> (!pslverr && prdata == 32'h0));
endmodule

bind apb_mem_slave apb_mem_slave_chk #(.IDX_W(IDX_W), .MAP_LIMIT(MAP_LIMIT)) u_chk (.*);

// File: tb/apb_mem_slave_tb.sv
module apb_mem_slave_tb;
    localparam int unsigned DEPTH = 256;
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam logic [31:0] LIMIT = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] paddr = '0, pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic        pready;
    logic [31:0] prdata;
    logic        pslverr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_data [DEPTH];
    bit          m_vld  [DEPTH];

    always #2 clk = ~clk;

    apb_mem_slave #(.DEPTH(DEPTH), .MAP_LIMIT(LIMIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .pready(pready), .prdata(prdata), .pslverr(pslverr)
    );

    function automatic int unsigned widx(input logic [31:0] a);
        return int'(a[IDX_W+1:2]);
    endfunction

    function automatic logic [31:0] exp_read(input logic [31:0] a);
        if (a >= LIMIT) return 32'h0;
        return m_vld[widx(a)] ? m_data[widx(a)] : 32'h0;
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] a, input logic [31:0] d,
                                              input logic [3:0] s);
        logic [31:0] base = exp_read(a);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = s[i] ? d[i*8 +: 8] : base[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, output logic [31:0] rd,
                        output logic err, output logic rdy);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; err = pslverr; rdy = pready;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic do_write(input string tag, input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] s);
        logic [31:0] rd; logic err, rdy;
        logic [31:0] nw = exp_merge(a, d, s);
        xfer(1'b1, a, d, s, rd, err, rdy);
        chk({tag, " err"}, {31'b0, err}, {31'b0, (a >= LIMIT)});
        chk("R8 ready", {31'b0, rdy}, 32'd1);
        if (a < LIMIT) begin
            m_data[widx(a)] = nw;
            m_vld[widx(a)]  = 1'b1;
        end
    endtask

    task automatic do_read(input string tag, input logic [31:0] a);
        logic [31:0] rd; logic err, rdy;
        logic [31:0] e = exp_read(a);
        xfer(1'b0, a, 32'h0, 4'h0, rd, err, rdy);
        chk({tag, " data"}, rd, e);
        chk({tag, " err"}, {31'b0, err}, {31'b0, (a >= LIMIT)});
        chk("R8 ready", {31'b0, rdy}, 32'd1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < int'(DEPTH); i++) m_vld[i] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < int'(DEPTH); i++) begin m_vld[i] = 1'b0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R9 idle err", {31'b0, pslverr}, 32'd0);
        chk("R9 idle data", prdata, 32'h0);

        do_read("R5 unwritten", 32'h0000_0040);
        do_read("R1 last word", 32'h000F_FFFC);

        do_write("R2 full", 32'h0000_0010, 32'hCAFE_F00D, 4'hF);
        do_read("R2 readback", 32'h0000_0010);
        do_write("R4 fresh lane", 32'h0000_0020, 32'h1122_3344, 4'b0100);
        chk("R4 model", exp_read(32'h20), 32'h0022_0000);
        do_read("R4 readback", 32'h0000_0020);
        do_write("R3 merge", 32'h0000_0010, 32'hAABB_CCDD, 4'b1001);
        chk("R3 model", exp_read(32'h10), 32'hAAFE_F0DD);
        do_read("R3 readback", 32'h0000_0010);

        do_write("R2 word0", 32'h0000_0000, 32'h1234_5678, 4'hF);
        do_write("R7 unmapped", 32'h0010_0000, 32'hFFFF_FFFF, 4'hF);
        do_read("R7 word0 kept", 32'h0000_0000);
        do_read("R6 unmapped", 32'h0010_0010);
        do_read("R6 top", 32'hFFFF_FFFC);

        // setup phase alone must not commit or raise the error
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 32'h0000_0010;
        pwdata = 32'h0; pstrb = 4'hF;
        #1;
        chk("R9 setup err", {31'b0, pslverr}, 32'd0);
        chk("R9 setup data", prdata, 32'h0);
        @(negedge clk);
        paddr = 32'h0020_0000;
        #1;
        chk("R9 setup unmapped err", {31'b0, pslverr}, 32'd0);
        @(negedge clk);
        psel = 1'b0;
        do_read("R9 no commit", 32'h0000_0010);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] a;
            bit wr = ($urandom % 2) == 1;
            if (($urandom % 10) == 0) a = LIMIT + ($urandom % 32'h0FF0_0000);
            else a = {{(30-IDX_W){1'b0}}, IDX_W'($urandom), 2'($urandom)};
            if (wr) do_write("R3 random write", a, $urandom, 4'($urandom));
            else    do_read("R3 random read", a);
        end

        do_reset();
        do_read("R10 after reset", 32'h0000_0010);
        do_read("R10 after reset", 32'h0000_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule